// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers up to 32 level interrupt inputs and presents one interrupt request to a processor. Each input passes through a polarity stage. Software then chooses, per source, whether the status bit follows the input level or latches its rising edge. Status is gated by an enable set, and the survivors compete on a 3-bit priority in which lower values win. The winner is reported only if its priority lies strictly below a programmable 4-bit threshold.

A handler first reads the claim register. That read returns the winning source number, copies the threshold into a save register and loads the threshold with the winner's priority. As a result, only strictly more urgent sources can interrupt the handler. Reading the acknowledge register at the end of the handler returns the saved value and puts it back into the threshold, which closes the request.

Register access is a simple single-cycle bus. Read data is combinational from the current state. Every write and every read side effect takes place at the clock edge that ends the access.

Top module: `prio_vic`

## Requirements
- R1: The masked-status register (word 0) reads the selected status ANDed with the enable set.
- R2: In the sticky-select register (word 9), a 1 makes that source's status bit (word 1) read its sticky bit and a 0 makes it read the polarity-adjusted input. Writing 1s to word 1 clears the corresponding sticky bits.
- R3: A sticky bit sets on a rising edge of the polarity-adjusted input, one clock after the edge. When a set and a clear fall in the same cycle, the set wins. A clear while the input stays high leaves the bit cleared.
- R4: In the polarity register (word 8), a 0 bit inverts that source's input.
- R5: Writing 1s to word 2 sets enable bits and writing 1s to word 3 clears them. Zero bits are ignored, and both words read the enable set.
- R6: Each source has a priority register at word 32+n (3 bits, lower wins). Among eligible sources the lowest priority value wins, and ties go to the lowest source number.
- R7: A source whose priority is greater than or equal to the threshold (word 7, 4 bits) is blocked. With nothing eligible, the number reads 32 and irq_o is low. Otherwise irq_o is high.
- R8: Reading word 4 returns the winning number and changes no state.
- R9: Reading word 5 returns the winning number, copies the threshold into the save register, and loads the threshold with the winner's priority. If nothing is eligible, the threshold is left unchanged.
- R10: Reading word 6 returns the save register and restores the threshold from it.
- R11: After reset, enables, sticky bits and sticky-select are 0, polarity is all ones, the threshold and save register are 8, every priority is 7 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt inputs, synchronous to clk |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the nested case. A claim has already lowered the threshold, a more urgent source then arrives and is claimed in turn, and the acknowledge must hand back the value saved by the second claim. The stimulus builds this case step by step. It holds a medium-priority source high, claims it, raises a higher-priority source, and then reads the threshold after each claim and acknowledge. The same-cycle race between a sticky edge and a clear is produced by driving the input edge and the clear write on the same clock.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
   localparam int ADDR_W    = 6;
   localparam int PRIO_BASE = 32;

   typedef enum logic [ADDR_W-1:0] {
      A_MASKED = 6'd0,
      A_STATUS = 6'd1,
      A_EN_SET = 6'd2,
      A_EN_CLR = 6'd3,
      A_NUM    = 6'd4,
      A_CLAIM  = 6'd5,
      A_ACK    = 6'd6,
      A_THRESH = 6'd7,
      A_POLAR  = 6'd8,
      A_STKSEL = 6'd9
   } reg_addr_e;
endpackage

// File: rtl/vic_src_status.sv
`timescale 1ns/1ps
module vic_src_status #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic            pol_wr,
   input  logic            sel_wr,
   input  logic            en_set_wr,
   input  logic            en_clr_wr,
   input  logic            stk_clr_wr,
   input  logic [NSRC-1:0] wmask,
   output logic [NSRC-1:0] pol_q,
   output logic [NSRC-1:0] sel_q,
   output logic [NSRC-1:0] en_q,
   output logic [NSRC-1:0] status,
   output logic [NSRC-1:0] masked
);
   logic [NSRC-1:0] adj, adj_q, rise, sticky_q;

   assign adj  = src_i ~^ pol_q;
   assign rise = adj & ~adj_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q    <= '1;
         sel_q    <= '0;
         en_q     <= '0;
         adj_q    <= '0;
         sticky_q <= '0;
      end else begin
         adj_q    <= adj;
         sticky_q <= (sticky_q & ~(stk_clr_wr ? wmask : '0)) | rise;
         if (pol_wr)    pol_q <= wmask;
         if (sel_wr)    sel_q <= wmask;
         if (en_set_wr) en_q  <= en_q | wmask;
         if (en_clr_wr) en_q  <= en_q & ~wmask;
      end
   end

   assign status = (sel_q & sticky_q) | (~sel_q & adj);
   assign masked = status & en_q;

   p_sticky_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((sticky_q & $past(rise)) == $past(rise)));
   p_sticky_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_clr_wr && ((wmask & rise) == '0)) |=> ((sticky_q & $past(wmask)) == '0));
   p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_wr |=> ((en_q & $past(wmask)) == $past(wmask)));
   p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_wr |=> ((en_q & $past(wmask)) == '0));
endmodule

// File: rtl/vic_prio_arb.sv
`timescale 1ns/1ps
module vic_prio_arb #(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 3,
   localparam int THR_W = PRIO_W + 1,
   localparam int NUM_W = $clog2(NSRC + 1)
) (
   input  logic [NSRC-1:0]             masked,
   input  logic [NSRC-1:0][PRIO_W-1:0] prio,
   input  logic [THR_W-1:0]            thr,
   output logic                        win_valid,
   output logic [NUM_W-1:0]            win_num,
   output logic [PRIO_W-1:0]           win_prio
);
   logic             found;
   logic [NUM_W-1:0] best_num;

   // Scan from the top down with <= so equal priorities settle on the lowest index.
   always_comb begin
      found    = 1'b0;
      best_num = '0;
      win_prio = '1;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (masked[i] && (!found || prio[i] <= win_prio)) begin
            found    = 1'b1;
            win_prio = prio[i];
            best_num = NUM_W'(i);
         end
      end
      win_valid = found && ({1'b0, win_prio} < thr);
      win_num   = win_valid ? best_num : NUM_W'(NSRC);
   end
endmodule

// File: rtl/vic_thr_ctl.sv
`timescale 1ns/1ps
module vic_thr_ctl #(
   parameter int THR_W = 4,
   parameter int THR_RST = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_wr,
   input  logic [THR_W-1:0] thr_wdata,
   input  logic             claim,
   input  logic             ack,
   input  logic             win_valid,
   input  logic [THR_W-1:0] win_prio,
   output logic [THR_W-1:0] thr_q,
   output logic [THR_W-1:0] save_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= THR_W'(THR_RST);
         save_q <= THR_W'(THR_RST);
      end else if (thr_wr) begin
         thr_q <= thr_wdata;
      end else if (claim) begin
         save_q <= thr_q;
         if (win_valid) thr_q <= win_prio;
      end else if (ack) begin
         thr_q <= save_q;
      end
   end

   p_claim_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
      claim |=> (save_q == $past(thr_q)));
   p_ack_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (thr_q == $past(save_q)));
endmodule

// File: rtl/prio_vic.sv
`timescale 1ns/1ps
module prio_vic #(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 3,
   parameter int DATA_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NSRC-1:0]            src_i,
   input  logic                       bus_sel,
   input  logic                       bus_wr,
   input  logic [vic_pkg::ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic                       irq_o
);
   import vic_pkg::*;

   localparam int THR_W   = PRIO_W + 1;
   localparam int NUM_W   = $clog2(NSRC + 1);
   localparam int THR_RST = 1 << PRIO_W;

   if (NSRC < 1 || NSRC > DATA_W || NSRC > 32) begin : g_bad_nsrc
      $error("prio_vic: NSRC out of range");
   end
   if (PRIO_W < 1 || THR_W > DATA_W) begin : g_bad_prio
      $error("prio_vic: PRIO_W out of range");
   end

   logic wr_en, rd_en, claim, ack;
   assign wr_en = bus_sel &  bus_wr;
   assign rd_en = bus_sel & ~bus_wr;
   assign claim = rd_en && (bus_addr == A_CLAIM);
   assign ack   = rd_en && (bus_addr == A_ACK);

   logic [NSRC-1:0] pol_q, sel_q, en_q, status, masked;

   vic_src_status #(.NSRC(NSRC)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i),
      .pol_wr     (wr_en && bus_addr == A_POLAR),
      .sel_wr     (wr_en && bus_addr == A_STKSEL),
      .en_set_wr  (wr_en && bus_addr == A_EN_SET),
      .en_clr_wr  (wr_en && bus_addr == A_EN_CLR),
      .stk_clr_wr (wr_en && bus_addr == A_STATUS),
      .wmask      (bus_wdata[NSRC-1:0]),
      .pol_q      (pol_q),
      .sel_q      (sel_q),
      .en_q       (en_q),
      .status     (status),
      .masked     (masked)
   );

   logic [NSRC-1:0][PRIO_W-1:0] prio_q;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_prio
      localparam int unsigned MY_ADDR = PRIO_BASE + gi;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_q[gi] <= '1;
         else if (wr_en && bus_addr == MY_ADDR[ADDR_W-1:0])
            prio_q[gi] <= bus_wdata[PRIO_W-1:0];
      end
   end

   logic              win_valid;
   logic [NUM_W-1:0]  win_num;
   logic [PRIO_W-1:0] win_prio;
   logic [THR_W-1:0]  thr_q, save_q;

   vic_prio_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
      .masked    (masked),
      .prio      (prio_q),
      .thr       (thr_q),
      .win_valid (win_valid),
      .win_num   (win_num),
      .win_prio  (win_prio)
   );

   vic_thr_ctl #(.THR_W(THR_W), .THR_RST(THR_RST)) u_thr (
      .clk       (clk),
      .rst_n     (rst_n),
      .thr_wr    (wr_en && bus_addr == A_THRESH),
      .thr_wdata (bus_wdata[THR_W-1:0]),
      .claim     (claim),
      .ack       (ack),
      .win_valid (win_valid),
      .win_prio  (THR_W'(win_prio)),
      .thr_q     (thr_q),
      .save_q    (save_q)
   );

   assign irq_o = win_valid;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_MASKED:          bus_rdata = DATA_W'(masked);
         A_STATUS:          bus_rdata = DATA_W'(status);
         A_EN_SET, A_EN_CLR: bus_rdata = DATA_W'(en_q);
         A_NUM, A_CLAIM:    bus_rdata = DATA_W'(win_num);
         A_ACK:             bus_rdata = DATA_W'(save_q);
         A_THRESH:          bus_rdata = DATA_W'(thr_q);
         A_POLAR:           bus_rdata = DATA_W'(pol_q);
         A_STKSEL:          bus_rdata = DATA_W'(sel_q);
         default: begin
            for (int i = 0; i < NSRC; i++)
               if (bus_addr == ADDR_W'(PRIO_BASE + i)) bus_rdata = DATA_W'(prio_q[i]);
         end
      endcase
   end

   // R9: a claimed source is blocked by its own priority in the next cycle.
   p_claim_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && win_valid) |=> (win_num != $past(win_num)));
   p_num_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && bus_addr == A_NUM) |=> $stable(thr_q));
   p_thr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q == '0) |-> !irq_o);
   p_winner_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (masked != '0));
endmodule

// File: tb/prio_vic_bench.sv
`timescale 1ns/1ps
module prio_vic_bench;
   import vic_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prio_vic u_prio_vic (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
   );

   // {src[38:7], expected number[6:1], expected irq[0]}; priority of n is (5n) mod 8
   localparam logic [38:0] VEC [10] = '{
      {32'h0000_0000, 6'd32, 1'b0},
      {32'h0000_0002, 6'd1,  1'b1},
      {32'h0000_0022, 6'd5,  1'b1},
      {32'h0000_0101, 6'd0,  1'b1},
      {32'h0000_0100, 6'd8,  1'b1},
      {32'h8000_0000, 6'd31, 1'b1},
      {32'h8000_0008, 6'd31, 1'b1},
      {32'h0000_0048, 6'd6,  1'b1},
      {32'hFFFF_FFFF, 6'd0,  1'b1},
      {32'hFFFF_FFFE, 6'd8,  1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [5:0] a, input logic [31:0] d,
                         output logic [31:0] r);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      #2 r = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      logic [31:0] r;
      access(1'b1, a, d, r);
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] r;
      access(1'b0, a, '0, r);
      check(req, r, exp);
   endtask

   task automatic set_src(input logic [31:0] v);
      @(negedge clk);
      src = v;
      #2;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      #2 check("R11 irq", 32'(irq), 32'd0);
      rd_chk("R11 enables", A_EN_SET, 32'h0);
      rd_chk("R11 polarity", A_POLAR, 32'hFFFF_FFFF);
      rd_chk("R11 threshold", A_THRESH, 32'd8);
      rd_chk("R11 sticky select", A_STKSEL, 32'h0);
      rd_chk("R11 save", A_ACK, 32'd8);
      rd_chk("R11 priority", 6'(PRIO_BASE + 5), 32'd7);
      rd_chk("R11 number", A_NUM, 32'd32);

      for (int i = 0; i < 32; i++) wr(6'(PRIO_BASE + i), 32'((i * 5) % 8));
      rd_chk("R6 priority readback", 6'(PRIO_BASE + 3), 32'd7);
      wr(A_EN_SET, 32'hFFFF_FFFF);

      // R6/R7 table walk
      for (int v = 0; v < 10; v++) begin
         set_src(VEC[v][38:7]);
         check("R7 irq table", 32'(irq), 32'(VEC[v][0]));
         rd_chk("R6 number table", A_NUM, 32'(VEC[v][6:1]));
      end

      // R4 polarity
      set_src(32'h0);
      wr(A_POLAR, 32'hFFFF_FFFB);
      rd_chk("R4 polarity readback", A_POLAR, 32'hFFFF_FFFB);
      rd_chk("R4 inverted status", A_STATUS, 32'h4);
      rd_chk("R4 inverted number", A_NUM, 32'd2);
      wr(A_POLAR, 32'hFFFF_FFFF);

      // R5 enable set/clear, R1 masked
      set_src(32'h10);
      rd_chk("R5 enabled number", A_NUM, 32'd4);
      wr(A_EN_CLR, 32'h0000_00F0);
      rd_chk("R5 set view", A_EN_SET, 32'hFFFF_FF0F);
      rd_chk("R5 clear view", A_EN_CLR, 32'hFFFF_FF0F);
      rd_chk("R1 masked off", A_MASKED, 32'h0);
      rd_chk("R1 status still", A_STATUS, 32'h10);
      check("R5 irq disabled", 32'(irq), 32'd0);
      rd_chk("R5 number disabled", A_NUM, 32'd32);
      wr(A_EN_SET, 32'h0000_00F0);
      rd_chk("R1 masked on", A_MASKED, 32'h10);

      // R7 threshold boundaries
      set_src(32'h24);
      wr(A_THRESH, 32'd2);
      rd_chk("R7 below threshold", A_NUM, 32'd5);
      set_src(32'h04);
      check("R7 irq blocked", 32'(irq), 32'd0);
      rd_chk("R7 equal blocked", A_NUM, 32'd32);
      wr(A_THRESH, 32'd3);
      rd_chk("R7 just below", A_NUM, 32'd2);
      wr(A_THRESH, 32'd0);
      set_src(32'h101);
      rd_chk("R7 zero blocks all", A_NUM, 32'd32);
      wr(A_THRESH, 32'd8);

      // R2/R3 sticky
      set_src(32'h0);
      wr(A_STATUS, 32'hFFFF_FFFF);
      wr(A_STKSEL, 32'hFFFF_FFFF);
      rd_chk("R2 sticky empty", A_STATUS, 32'h0);
      set_src(32'h40);
      set_src(32'h0);
      rd_chk("R3 sticky held", A_STATUS, 32'h40);
      rd_chk("R2 sticky number", A_NUM, 32'd6);
      wr(A_STATUS, 32'h40);
      rd_chk("R2 sticky cleared", A_STATUS, 32'h0);
      check("R2 irq after clear", 32'(irq), 32'd0);
      @(negedge clk);
      src = 32'h40;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STATUS; bus_wdata = 32'h40;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
      rd_chk("R3 set wins", A_STATUS, 32'h40);
      wr(A_STATUS, 32'h40);
      rd_chk("R3 no new edge", A_STATUS, 32'h0);
      set_src(32'h0);
      wr(A_STKSEL, 32'h0);

      // R8/R9/R10 claim and acknowledge
      set_src(32'h04);
      rd_chk("R8 number", A_NUM, 32'd2);
      rd_chk("R8 threshold kept", A_THRESH, 32'd8);
      rd_chk("R9 claim number", A_CLAIM, 32'd2);
      rd_chk("R9 threshold raised", A_THRESH, 32'd2);
      check("R9 irq off", 32'(irq), 32'd0);
      set_src(32'h24);
      check("R9 nested irq", 32'(irq), 32'd1);
      rd_chk("R9 nested claim", A_CLAIM, 32'd5);
      rd_chk("R9 nested threshold", A_THRESH, 32'd1);
      rd_chk("R10 ack value", A_ACK, 32'd2);
      rd_chk("R10 restored", A_THRESH, 32'd2);
      set_src(32'h0);
      rd_chk("R9 empty claim", A_CLAIM, 32'd32);
      rd_chk("R9 empty keeps threshold", A_THRESH, 32'd2);
      wr(A_THRESH, 32'd8);
      set_src(32'h04);
      rd_chk("R9 claim again", A_CLAIM, 32'd2);
      rd_chk("R10 ack returns", A_ACK, 32'd8);
      rd_chk("R10 threshold back", A_THRESH, 32'd8);
      check("R10 irq back", 32'(irq), 32'd1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule